// File: doc/BRIEF.md
# ADC Auto-Trigger Source Selector

This block decides when an analog-to-digital converter begins a new conversion on its own. A 3-bit field in a small control register picks one of eight source flags. A rising edge on the picked flag produces a start pulse one clock wide. Source 0 is the converter's own completion flag, so picking it makes the converter run freely, one conversion after another.

Automatic starts happen only when two bits are both set: an auto-trigger enable and a converter enable. An edge that arrives while a conversion is still running is dropped and is not held for later.

Writing the select field can itself create an edge. If the old source flag was low and the new one is high, the write produces a start. A write that selects source 0 never produces a start, even when the completion flag is high at that moment.

Top module: `adc_trig_sel`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0x00 and `start_pulse` is low.
- R2: A write stores `ctrl_wdata[6]` and `ctrl_wdata[2:0]`. On read, bit 6 and bits 2:0 return the stored values, and bits 7 and 5:3 always read 0.
- R3: A low-to-high change on the selected flag makes `start_pulse` high for exactly one cycle, in the cycle after the clock edge that first samples the flag high. A flag that stays high gives no further pulses.
- R4: Edges on flags other than the selected one have no effect on `start_pulse`.
- R5: While `auto_en` is low, no start pulse is produced.
- R6: While `adc_en` is low, no start pulse is produced.
- R7: Writing a select value whose flag is high, while the previously selected flag is low, produces one start pulse. The pulse appears two cycles after the write cycle.
- R8: Writing select value 0 never produces a pulse from the switch itself, even if `src_flags[0]` is high.
- R9: A trigger edge seen while `conv_busy` is high produces no pulse, and no pulse follows when `conv_busy` falls.
- R10: With select value 0, a rising edge of `src_flags[0]` (the completion flag) produces a start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read value |
| auto_en | input | 1 | Auto-trigger enable |
| adc_en | input | 1 | Converter enable |
| conv_busy | input | 1 | A conversion is running |
| src_flags | input | 8 | Trigger source flags; bit 0 is the completion flag |
| start_pulse | output | 1 | One-cycle conversion start |

## Verification
A select write and the busy signal can act in the same cycle. The bench writes a switch from a low source to a high source while `conv_busy` is high. The edge that the switch creates must then produce no pulse, and no pulse may follow once busy drops. A second collision comes from a write into free-running mode while the completion flag is high. That write must stay silent, but a later real rise of the completion flag must still produce a start.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
    localparam int SRC_CNT   = 8;
    localparam int SEL_W     = $clog2(SRC_CNT);
    localparam int REG_W     = 8;
    localparam int AUX_BIT   = 6;
    localparam logic [SEL_W-1:0] FREE_RUN_SEL = '0;

    typedef struct packed {
        logic             aux;
        logic [SEL_W-1:0] sel;
    } trig_ctrl_t;

    function automatic logic [REG_W-1:0] pack_ctrl(input trig_ctrl_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[AUX_BIT]     = c.aux;
        v[SEL_W-1:0]   = c.sel;
        return v;
    endfunction

    function automatic trig_ctrl_t unpack_ctrl(input logic [REG_W-1:0] v);
        trig_ctrl_t c;
        c.aux = v[AUX_BIT];
        c.sel = v[SEL_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/trig_ctrl_reg.sv
module trig_ctrl_reg
    import adc_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output trig_ctrl_t       ctrl,
    output logic [REG_W-1:0] rdata
);
    trig_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr)
            ctrl_q <= unpack_ctrl(wdata);
    end

    assign ctrl  = ctrl_q;
    assign rdata = pack_ctrl(ctrl_q);
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det
    import adc_trig_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SRC_CNT-1:0] flags,
    input  logic [SEL_W-1:0]   sel,
    input  logic               wr,
    input  logic [SEL_W-1:0]   wr_sel,
    output logic               rise
);
    logic cur_flag;
    logic prev_q;
    logic to_free_run;

    assign cur_flag    = flags[sel];
    assign to_free_run = wr && (wr_sel == FREE_RUN_SEL);
    assign rise        = cur_flag && !prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else if (to_free_run)
            prev_q <= flags[FREE_RUN_SEL];
        else
            prev_q <= cur_flag;
    end
endmodule

// File: rtl/trig_start_gen.sv
module trig_start_gen (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic auto_en,
    input  logic adc_en,
    input  logic busy,
    output logic start
);
    logic start_q;

    always_ff @(posedge clk) begin
        if (rst)
            start_q <= 1'b0;
        else
            start_q <= rise && auto_en && adc_en && !busy;
    end

    assign start = start_q;
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_trig_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         ctrl_wr,
    input  logic [7:0]   ctrl_wdata,
    output logic [7:0]   ctrl_rdata,
    input  logic         auto_en,
    input  logic         adc_en,
    input  logic         conv_busy,
    input  logic [7:0]   src_flags,
    output logic         start_pulse
);
    trig_ctrl_t ctrl;
    logic       rise;

    trig_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctrl_wr),
        .wdata (ctrl_wdata),
        .ctrl  (ctrl),
        .rdata (ctrl_rdata)
    );

    trig_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .flags  (src_flags),
        .sel    (ctrl.sel),
        .wr     (ctrl_wr),
        .wr_sel (ctrl_wdata[SEL_W-1:0]),
        .rise   (rise)
    );

    trig_start_gen u_start (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise),
        .auto_en (auto_en),
        .adc_en  (adc_en),
        .busy    (conv_busy),
        .start   (start_pulse)
    );
endmodule

// File: rtl/adc_trig_sel_chk.sv
module adc_trig_sel_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctrl_wr,
    input logic [7:0] ctrl_wdata,
    input logic [7:0] ctrl_rdata,
    input logic       auto_en,
    input logic       adc_en,
    input logic       conv_busy,
    input logic [7:0] src_flags,
    input logic       start_pulse
);
    // R3
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R5
    auto_gate_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(auto_en));

    // R6
    adc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(adc_en));

    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> !$past(conv_busy));

    // R2
    sel_store_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl_rdata[2:0] == $past(ctrl_wdata[2:0])));

    // R8
    free_run_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_wdata[2:0] == 3'd0) ##1 (src_flags[0] == $past(src_flags[0]))
        |=> !start_pulse);
endmodule

bind adc_trig_sel adc_trig_sel_chk u_chk (.*);

// File: tb/tb_adc_trig_sel.sv
module tb_adc_trig_sel;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctrl_wr;
    logic [7:0] ctrl_wdata;
    logic [7:0] ctrl_rdata;
    logic       auto_en, adc_en, conv_busy;
    logic [7:0] src_flags;
    logic       start_pulse;

    int checks = 0;
    int errors = 0;
    bit exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    adc_trig_sel dut (.*);

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected start value after every edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({7'd0, start_pulse}, {7'd0, e}, t);
            end
        end
    end

    // driver: one cycle with an expected start value after its edge
    task automatic cyc(input bit e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        #2;
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_sel(input logic [7:0] d, input bit e, input string tag);
        ctrl_wr = 1'b1;
        ctrl_wdata = d;
        cyc(e, tag);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; ctrl_wr = 1'b0; ctrl_wdata = 8'h00;
        auto_en = 1'b1; adc_en = 1'b1; conv_busy = 1'b0; src_flags = 8'h00;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        // R1 reset state
        check(ctrl_rdata, 8'h00, "R1 rdata");
        check({7'd0, start_pulse}, 8'h00, "R1 start");

        // R2 readback masks
        wr_sel(8'hFF, 1'b0, "R2 write");
        check(ctrl_rdata, 8'h47, "R2 all ones");
        wr_sel(8'hB9, 1'b0, "R2 write");
        check(ctrl_rdata, 8'h01, "R2 mixed");
        cyc(1'b0, "R2 idle");

        // R3 edge on selected source 1
        src_flags[1] = 1'b1;
        cyc(1'b1, "R3 pulse");
        cyc(1'b0, "R3 one cycle");
        cyc(1'b0, "R3 level no retrigger");
        src_flags[1] = 1'b0;
        cyc(1'b0, "R3 fall");

        // R4 unselected sources
        src_flags = 8'hFC;
        cyc(1'b0, "R4 other flags");
        cyc(1'b0, "R4 other flags");
        src_flags = 8'h00;
        cyc(1'b0, "R4 idle");

        // R5 auto enable low
        auto_en = 1'b0;
        src_flags[1] = 1'b1;
        cyc(1'b0, "R5 gated");
        cyc(1'b0, "R5 gated");
        auto_en = 1'b1;
        cyc(1'b0, "R5 no late pulse");
        src_flags[1] = 1'b0;
        cyc(1'b0, "R5 idle");

        // R6 converter enable low
        adc_en = 1'b0;
        src_flags[1] = 1'b1;
        cyc(1'b0, "R6 gated");
        adc_en = 1'b1;
        cyc(1'b0, "R6 no late pulse");
        src_flags[1] = 1'b0;
        cyc(1'b0, "R6 idle");

        // R7 switch from low source 1 to high source 2
        src_flags[2] = 1'b1;
        cyc(1'b0, "R7 setup");
        wr_sel(8'h02, 1'b0, "R7 write cycle");
        cyc(1'b1, "R7 switch pulse");
        cyc(1'b0, "R7 one cycle");

        // R8 switch into free running with flag 0 high
        src_flags = 8'h01;
        cyc(1'b0, "R8 setup");
        wr_sel(8'h00, 1'b0, "R8 write cycle");
        cyc(1'b0, "R8 no switch pulse");
        cyc(1'b0, "R8 no switch pulse");

        // R10 free running completion edge
        src_flags[0] = 1'b0;
        cyc(1'b0, "R10 fall");
        src_flags[0] = 1'b1;
        cyc(1'b1, "R10 pulse");
        cyc(1'b0, "R10 one cycle");
        src_flags[0] = 1'b0;
        cyc(1'b0, "R10 idle");

        // R9 busy drops edge, no queueing
        wr_sel(8'h03, 1'b0, "R9 sel");
        cyc(1'b0, "R9 idle");
        conv_busy = 1'b1;
        src_flags[3] = 1'b1;
        cyc(1'b0, "R9 busy edge");
        conv_busy = 1'b0;
        cyc(1'b0, "R9 not queued");
        cyc(1'b0, "R9 not queued");

        // R9 with R7 same cycle: switch edge while busy
        src_flags = 8'h20;
        wr_sel(8'h04, 1'b0, "R9 sel low source");
        cyc(1'b0, "R9 idle");
        conv_busy = 1'b1;
        wr_sel(8'h05, 1'b0, "R9 switch while busy");
        cyc(1'b0, "R9 switch edge dropped");
        conv_busy = 1'b0;
        cyc(1'b0, "R9 switch not queued");
        cyc(1'b0, "R9 switch not queued");

        repeat (3) @(posedge clk);
        #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule